// File: doc/BRIEF.md
# Call and Interrupt Return-Context Stack Sequencer

This block saves and restores a processor's return context on a program stack held in byte-wide data memory. The context is a 14-bit program counter plus the carry and zero flags, packed into two bytes. An 8-bit stack pointer starts at zero after reset and grows toward higher addresses. The core issues one of four requests: interrupt acknowledge, subroutine call, subroutine return, or return from interrupt. The sequencer then drives the read or write cycles on a single-port synchronous RAM interface, steps the pointer one byte at a time, and delivers the restored values.

A save writes the low PC byte at the pointer and increments it. It then writes the byte {carry, zero, PC[13:8]} at the new pointer and increments again. A restore runs the same steps in reverse. It decrements the pointer and reads the flag/high byte, then decrements again and reads the low byte. A plain return restores only the PC. A return from interrupt also restores both flags and sets the interrupt enable. An interrupt acknowledge clears the interrupt enable. The core can load the pointer with an accumulator value while the sequencer is idle. The pointer has no read path. Each request keeps `busy` high for three cycles, and `done` then pulses for one cycle.

Top module: `ctx_stack_seq`

## Requirements
- R1: After reset, busy, done, mem_we, mem_re, pc_out, carry_out, zero_out and int_en are all 0, and the stack pointer is 0x00, so the first save writes to address 0x00.
- R2: A save (req_op 0 = interrupt acknowledge, 1 = call) writes PC[7:0] at address P in the first busy cycle. It writes {carry at bit 7, zero at bit 6, PC[13:8] at bits 5:0} at P+1 in the second busy cycle. The pointer ends at P+2.
- R3: An interrupt acknowledge clears int_en when done rises. A call leaves int_en unchanged.
- R4: A restore (req_op 2 = return, 3 = return from interrupt) reads address P-1 in the first busy cycle and P-2 in the second. The pointer ends at P-2.
- R5: A return sets pc_out to {bits 5:0 of the byte at P-1, byte at P-2}. carry_out, zero_out and int_en keep their previous values.
- R6: A return from interrupt restores pc_out the same way as R5. It also sets carry_out from bit 7 and zero_out from bit 6 of the byte at P-1, and sets int_en to 1.
- R7: A request is accepted on an edge where busy is low. busy is then high for exactly three cycles with no memory access in the third. done is high for exactly one cycle after that, with busy low and the new outputs already valid.
- R8: When idle, a cycle with sp_wr high and req_valid low loads sp_wr_val into the stack pointer.
- R9: sp_wr has no effect while busy is high, or in a cycle where req_valid is also high.
- R10: Pointer arithmetic wraps modulo 256. A save at 0xFF writes 0xFF then 0x00. A restore at pointer 0x01 reads 0x00 then 0xFF.
- R11: req_valid is ignored while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when idle |
| req_op | input | 2 | 0 interrupt acknowledge, 1 call, 2 return, 3 return from interrupt |
| pc_in | input | 14 | Program counter to save |
| carry_in | input | 1 | Carry flag to save |
| zero_in | input | 1 | Zero flag to save |
| sp_wr | input | 1 | Load the stack pointer |
| sp_wr_val | input | 8 | Value to load into the stack pointer |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| mem_we | output | 1 | RAM write strobe |
| mem_re | output | 1 | RAM read strobe; data returns next cycle |
| mem_addr | output | 8 | RAM address |
| mem_wdata | output | 8 | RAM write data |
| mem_rdata | input | 8 | RAM read data, one cycle after mem_re |
| pc_out | output | 14 | Restored program counter |
| carry_out | output | 1 | Restored carry flag |
| zero_out | output | 1 | Restored zero flag |
| int_en | output | 1 | Interrupt enable state |

## Verification
Counting the accepting edge as edge one, the first memory cycle shows on the bus after that edge and the second after edge two. The idle third busy cycle follows edge three. `done`, together with the restored PC, flags and interrupt enable, is due right after edge four. The bench drives inputs on falling edges. At every falling edge it compares the strobes, address, write data, busy, done and all result outputs against a behavioural model. The model updates its expected pointer and context only in the `done` cycle, so each value is checked in the cycle it becomes due. Stray loads and requests are driven inside busy windows. Their effects are then judged by the addresses the next request uses.

// File: rtl/ctx_stack_pkg.sv
package ctx_stack_pkg;
  localparam int BYTE_W = 8;
  localparam int PC_W   = 2 * BYTE_W - 2;

  typedef enum logic [1:0] {
    OP_IRQ  = 2'd0,
    OP_CALL = 2'd1,
    OP_RET  = 2'd2,
    OP_RETI = 2'd3
  } ctx_op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WR_LO,
    ST_WR_HI,
    ST_RD_HI,
    ST_RD_LO,
    ST_FIN
  } ctx_st_e;

  function automatic logic op_saves(input ctx_op_e op);
    return (op == OP_IRQ) || (op == OP_CALL);
  endfunction

  function automatic logic [BYTE_W-1:0] pack_lo(input logic [PC_W-1:0] pc);
    return pc[BYTE_W-1:0];
  endfunction

  function automatic logic [BYTE_W-1:0] pack_hi(input logic [PC_W-1:0] pc,
                                               input logic c, input logic z);
    return {c, z, pc[PC_W-1:BYTE_W]};
  endfunction

  function automatic logic [PC_W-1:0] unpack_pc(input logic [BYTE_W-1:0] hi,
                                               input logic [BYTE_W-1:0] lo);
    return {hi[BYTE_W-3:0], lo};
  endfunction
endpackage

// File: rtl/ctx_sp_reg.sv
module ctx_sp_reg #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  input  logic             dec,
  input  logic             load,
  input  logic [PTR_W-1:0] load_val,
  output logic [PTR_W-1:0] sp
);
  localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

  always_ff @(posedge clk) begin
    if (!rst_n)     sp <= '0;
    else if (load)  sp <= load_val;
    else if (inc)   sp <= sp + ONE;
    else if (dec)   sp <= sp - ONE;
  end
endmodule

// File: rtl/ctx_seq_fsm.sv
module ctx_seq_fsm
  import ctx_stack_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    req_valid,
  input  ctx_op_e req_op,
  input  logic    ptr_load,
  output logic    busy,
  output logic    accept,
  output logic    wr_lo,
  output logic    wr_hi,
  output logic    rd_hi,
  output logic    rd_lo,
  output logic    fin,
  output logic    load_ok,
  output logic    done,
  output ctx_op_e op_q
);
  ctx_st_e st_q, st_d;

  assign busy    = (st_q != ST_IDLE);
  assign accept  = (st_q == ST_IDLE) && req_valid;
  assign load_ok = (st_q == ST_IDLE) && !req_valid && ptr_load;
  assign wr_lo   = (st_q == ST_WR_LO);
  assign wr_hi   = (st_q == ST_WR_HI);
  assign rd_hi   = (st_q == ST_RD_HI);
  assign rd_lo   = (st_q == ST_RD_LO);
  assign fin     = (st_q == ST_FIN);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (req_valid) st_d = op_saves(req_op) ? ST_WR_LO : ST_RD_HI;
      ST_WR_LO: st_d = ST_WR_HI;
      ST_WR_HI: st_d = ST_FIN;
      ST_RD_HI: st_d = ST_RD_LO;
      ST_RD_LO: st_d = ST_FIN;
      ST_FIN:   st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      op_q <= OP_IRQ;
      done <= 1'b0;
    end else begin
      st_q <= st_d;
      done <= fin;
      if (accept) op_q <= req_op;
    end
  end
endmodule

// File: rtl/ctx_result.sv
module ctx_result
  import ctx_stack_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              carry_in,
  input  logic              zero_in,
  input  logic              rd_lo,
  input  logic              fin,
  input  ctx_op_e           op_q,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [BYTE_W-1:0] save_lo,
  output logic [BYTE_W-1:0] save_hi,
  output logic [PC_W-1:0]   pc_out,
  output logic              carry_out,
  output logic              zero_out,
  output logic              int_en
);
  logic [PC_W-1:0]   pc_s;
  logic              c_s, z_s;
  logic [BYTE_W-1:0] hold;

  assign save_lo = pack_lo(pc_s);
  assign save_hi = pack_hi(pc_s, c_s, z_s);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_s      <= '0;
      c_s       <= 1'b0;
      z_s       <= 1'b0;
      hold      <= '0;
      pc_out    <= '0;
      carry_out <= 1'b0;
      zero_out  <= 1'b0;
      int_en    <= 1'b0;
    end else begin
      if (accept) begin
        pc_s <= pc_in;
        c_s  <= carry_in;
        z_s  <= zero_in;
      end
      if (rd_lo) hold <= mem_rdata;
      if (fin) begin
        unique case (op_q)
          OP_IRQ:  int_en <= 1'b0;
          OP_CALL: ;
          OP_RET:  pc_out <= unpack_pc(hold, mem_rdata);
          OP_RETI: begin
            pc_out    <= unpack_pc(hold, mem_rdata);
            carry_out <= hold[BYTE_W-1];
            zero_out  <= hold[BYTE_W-2];
            int_en    <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ctx_stack_seq.sv
module ctx_stack_seq
  import ctx_stack_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [PC_W-1:0]   pc_in,
  input  logic              carry_in,
  input  logic              zero_in,
  input  logic              sp_wr,
  input  logic [PTR_W-1:0]  sp_wr_val,
  output logic              busy,
  output logic              done,
  output logic              mem_we,
  output logic              mem_re,
  output logic [PTR_W-1:0]  mem_addr,
  output logic [BYTE_W-1:0] mem_wdata,
  input  logic [BYTE_W-1:0] mem_rdata,
  output logic [PC_W-1:0]   pc_out,
  output logic              carry_out,
  output logic              zero_out,
  output logic              int_en
);
  localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

  logic       accept, wr_lo, wr_hi, rd_hi, rd_lo, fin, load_ok;
  ctx_op_e    op_q;
  logic [PTR_W-1:0]  stk_ptr;
  logic [BYTE_W-1:0] save_lo, save_hi;

  ctx_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (ctx_op_e'(req_op)),
    .ptr_load  (sp_wr),
    .busy      (busy),
    .accept    (accept),
    .wr_lo     (wr_lo),
    .wr_hi     (wr_hi),
    .rd_hi     (rd_hi),
    .rd_lo     (rd_lo),
    .fin       (fin),
    .load_ok   (load_ok),
    .done      (done),
    .op_q      (op_q)
  );

  ctx_sp_reg #(.PTR_W(PTR_W)) u_sp (
    .clk      (clk),
    .rst_n    (rst_n),
    .inc      (wr_lo | wr_hi),
    .dec      (rd_hi | rd_lo),
    .load     (load_ok),
    .load_val (sp_wr_val),
    .sp       (stk_ptr)
  );

  ctx_result u_res (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .pc_in     (pc_in),
    .carry_in  (carry_in),
    .zero_in   (zero_in),
    .rd_lo     (rd_lo),
    .fin       (fin),
    .op_q      (op_q),
    .mem_rdata (mem_rdata),
    .save_lo   (save_lo),
    .save_hi   (save_hi),
    .pc_out    (pc_out),
    .carry_out (carry_out),
    .zero_out  (zero_out),
    .int_en    (int_en)
  );

  assign mem_we    = wr_lo | wr_hi;
  assign mem_re    = rd_hi | rd_lo;
  assign mem_addr  = mem_we ? stk_ptr : stk_ptr - ONE;
  assign mem_wdata = wr_hi ? save_hi : save_lo;
endmodule

// File: rtl/ctx_stack_chk.sv
module ctx_stack_chk #(
  parameter int PTR_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic             done,
  input logic             mem_we,
  input logic             mem_re,
  input logic [PTR_W-1:0] mem_addr,
  input logic             int_en,
  input logic [PTR_W-1:0] stk_ptr
);
  localparam logic [PTR_W-1:0] ONE = {{(PTR_W-1){1'b0}}, 1'b1};

  // R7
  no_rw_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  // R2
  wr_step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && $past(mem_we)) |-> mem_addr == $past(mem_addr) + ONE);

  // R4
  rd_step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_re && $past(mem_re)) |-> mem_addr == $past(mem_addr) - ONE);

  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3
  ie_clear_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(int_en) |-> done);

  // R6
  ie_set_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_en) |-> done);

  // R9
  ptr_no_load_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ($stable(stk_ptr) || stk_ptr == $past(stk_ptr) + ONE
              || stk_ptr == $past(stk_ptr) - ONE));
endmodule

bind ctx_stack_seq ctx_stack_chk #(.PTR_W(PTR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .done     (done),
  .mem_we   (mem_we),
  .mem_re   (mem_re),
  .mem_addr (mem_addr),
  .int_en   (int_en),
  .stk_ptr  (stk_ptr)
);

// File: tb/sim_ctx_stack_seq.sv
`timescale 1ns/1ps
module sim_ctx_stack_seq;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [1:0]  req_op = 2'd0;
  logic [13:0] pc_in = '0;
  logic        carry_in = 1'b0, zero_in = 1'b0;
  logic        sp_wr = 1'b0;
  logic [7:0]  sp_wr_val = '0;
  logic        busy, done, mem_we, mem_re;
  logic [7:0]  mem_addr, mem_wdata;
  logic [7:0]  mem_rdata;
  logic [13:0] pc_out;
  logic        carry_out, zero_out, int_en;

  logic [7:0] ram [256];

  ctx_stack_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .pc_in(pc_in), .carry_in(carry_in), .zero_in(zero_in),
    .sp_wr(sp_wr), .sp_wr_val(sp_wr_val), .busy(busy), .done(done),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .pc_out(pc_out),
    .carry_out(carry_out), .zero_out(zero_out), .int_en(int_en)
  );

  // behavioural single-port RAM, read data one cycle later
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) mem_rdata <= ram[mem_addr];
  end

  int total = 0, bad = 0;
  bit finished = 1'b0;
  int m_sp = 0, m_pc = 0;
  bit m_c = 0, m_z = 0, m_ie = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic see(input string tag, input bit eb, input bit ed, input bit ew,
                     input bit er, input int ea, input int ewd);
    chk(tag, "busy", int'(busy), int'(eb));
    chk(tag, "done", int'(done), int'(ed));
    chk(tag, "mem_we", int'(mem_we), int'(ew));
    chk(tag, "mem_re", int'(mem_re), int'(er));
    if (ew || er) chk(tag, "mem_addr", int'(mem_addr), ea);
    if (ew) chk(tag, "mem_wdata", int'(mem_wdata), ewd);
    chk(tag, "pc_out", int'(pc_out), m_pc);
    chk(tag, "carry_out", int'(carry_out), int'(m_c));
    chk(tag, "zero_out", int'(zero_out), int'(m_z));
    chk(tag, "int_en", int'(int_en), int'(m_ie));
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      see("R7", 0, 0, 0, 0, 0, 0);
    end
  endtask

  // mode 0 plain, 1 pointer load together with the request, 2 stray load and request while busy
  task automatic run_op(input int kind, input int pc, input bit c, input bit z,
                        input int mode, input string atag);
    int lo, hi, a1, a2;
    bit save;
    save = (kind < 2);
    req_valid = 1'b1; req_op = kind[1:0]; pc_in = pc[13:0];
    carry_in = c; zero_in = z;
    if (mode == 1) begin sp_wr = 1'b1; sp_wr_val = 8'h5A; end
    @(negedge clk);
    req_valid = 1'b0; sp_wr = 1'b0;
    if (save) begin
      lo = pc & 255;
      hi = (int'(c) << 7) | (int'(z) << 6) | ((pc >> 8) & 63);
      see(atag, 1, 0, 1, 0, m_sp, lo);
      if (mode == 2) begin req_valid = 1'b1; req_op = 2'd3; sp_wr = 1'b1; sp_wr_val = 8'hA5; end
      @(negedge clk);
      see(atag, 1, 0, 1, 0, (m_sp + 1) & 255, hi);
      @(negedge clk);
      see(mode == 2 ? "R11" : "R7", 1, 0, 0, 0, 0, 0);
      req_valid = 1'b0; sp_wr = 1'b0;
      @(negedge clk);
      m_sp = (m_sp + 2) & 255;
      if (kind == 0) m_ie = 1'b0;
      see(kind == 0 ? "R3" : "R7", 0, 1, 0, 0, 0, 0);
    end else begin
      a1 = (m_sp - 1) & 255;
      a2 = (m_sp - 2) & 255;
      see(atag, 1, 0, 0, 1, a1, 0);
      if (mode == 2) begin req_valid = 1'b1; req_op = 2'd1; sp_wr = 1'b1; sp_wr_val = 8'h3C; end
      @(negedge clk);
      see(atag, 1, 0, 0, 1, a2, 0);
      @(negedge clk);
      see(mode == 2 ? "R11" : "R7", 1, 0, 0, 0, 0, 0);
      req_valid = 1'b0; sp_wr = 1'b0;
      @(negedge clk);
      m_pc = ((int'(ram[a1]) & 63) << 8) | int'(ram[a2]);
      if (kind == 3) begin
        m_c = ram[a1][7];
        m_z = ram[a1][6];
        m_ie = 1'b1;
      end
      m_sp = a2;
      see(kind == 3 ? "R6" : "R5", 0, 1, 0, 0, 0, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 256; i++) ram[i] = 8'h00;
    mem_rdata = 8'h00;
    repeat (3) @(negedge clk);
    see("R1", 0, 0, 0, 0, 0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    see("R1", 0, 0, 0, 0, 0, 0);

    run_op(1, 'h1234, 1'b1, 1'b0, 0, "R1");   // first save lands at 0x00
    idle(1);
    run_op(0, 'h2ABC, 1'b0, 1'b1, 0, "R2");
    idle(1);
    run_op(3, 0, 1'b0, 1'b0, 0, "R4");        // RETI: 2ABC, c0 z1, ie set
    idle(1);
    run_op(0, 'h0155, 1'b1, 1'b1, 2, "R2");   // clears ie; stray load/request ignored
    idle(1);
    run_op(2, 0, 1'b0, 1'b0, 0, "R9");        // RET: flags kept, pointer not reloaded
    run_op(3, 0, 1'b0, 1'b0, 2, "R4");        // back to back, restores 1234 c1 z0
    idle(1);
    run_op(1, 'h0777, 1'b0, 1'b1, 1, "R9");   // load beside a request is dropped
    run_op(2, 0, 1'b0, 1'b0, 0, "R9");
    idle(1);

    sp_wr = 1'b1; sp_wr_val = 8'h80;           // R8
    @(negedge clk);
    sp_wr = 1'b0; m_sp = 'h80;
    see("R8", 0, 0, 0, 0, 0, 0);
    run_op(1, 'h2468, 1'b1, 1'b1, 0, "R8");
    idle(1);

    sp_wr = 1'b1; sp_wr_val = 8'hFF;           // R10
    @(negedge clk);
    sp_wr = 1'b0; m_sp = 'hFF;
    see("R8", 0, 0, 0, 0, 0, 0);
    run_op(1, 'h3FFF, 1'b0, 1'b0, 0, "R10");
    idle(1);
    run_op(3, 0, 1'b0, 1'b0, 0, "R10");
    idle(2);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog R7 actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule